// File: doc/BRIEF.md
# Pointer-Addressed Packet Page Window

This block gives a host byte-wide access to packet page memory through two pieces of state: a 16-bit pointer and a window of four byte lanes. The pointer carries the byte address inside a page together with two control bits. One control bit chooses which page the window reaches: either the page at the head of the receive queue or the page named by the packet number input. The other control bit makes the address step forward by one after every window access.

The host loads the pointer one byte at a time and then reads or writes through the window. With stepping off, the two-bit lane offset is added to the pointer address and the pointer keeps its value, so four neighbouring bytes can be reached without reloading it. With stepping on, the lane offset is ignored. Each access uses the pointer address, and the address then advances. It wraps inside its own field, and the control bits are left alone. Page memory is an internal synchronous RAM, so read data returns one cycle after the read is issued. The memory address, write strobe and write data are also driven out so that the access can be observed.

Top module: `pkt_window_port`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the pointer reads back as 0x0000 and `win_rvalid` is 0.
- R2: A pointer byte write changes only its own byte: `ptr_lo_we` loads bits [7:0], `ptr_hi_we` loads bits [15:8], and `ptr_lo_rdata` always returns bits [7:0].
- R3: `ptr_hi_rdata` returns pointer bits [15:8] ANDed with 0xF7, so its bit 3 (pointer bit 11) always reads 0.
- R4: Pointer bit 15 set selects page `rx_head_page`; clear selects page `pkt_num`. `mem_addr` is page × 2^ADDR_W plus the byte address.
- R5: With pointer bit 14 clear, the byte address is (pointer[ADDR_W-1:0] + `win_lane`) modulo 2^ADDR_W, and the pointer does not change.
- R6: With pointer bit 14 set, `win_lane` is ignored and the byte address is pointer[ADDR_W-1:0]. After the access, that field becomes (field + 1) modulo 2^ADDR_W, and bits [15:ADDR_W] are kept.
- R7: A window write drives `mem_we` = 1 and `mem_wdata` = `win_wdata` in the same cycle and stores the byte. `mem_we` is never 1 without `win_we`.
- R8: A window read returns the addressed byte on `win_rdata` with `win_rvalid` = 1 in the next cycle. Back-to-back reads stream one byte per cycle.
- R9: When `win_we` and `win_re` are both 1, only the write is performed. The pointer steps at most once, and `win_rvalid` stays 0 in the next cycle.
- R10: When a pointer byte write coincides with a window access, the access uses the old pointer, the written byte is loaded, and no step takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_lo_we | input | 1 | Load pointer bits [7:0] from `ptr_wbyte` |
| ptr_hi_we | input | 1 | Load pointer bits [15:8] from `ptr_wbyte` |
| ptr_wbyte | input | 8 | Byte written into the pointer |
| ptr_lo_rdata | output | 8 | Pointer bits [7:0] |
| ptr_hi_rdata | output | 8 | Pointer bits [15:8] masked with 0xF7 |
| win_we | input | 1 | Window write strobe |
| win_re | input | 1 | Window read strobe |
| win_lane | input | clog2(LANES) | Lane offset, used only when stepping is off |
| win_wdata | input | 8 | Byte written through the window |
| win_rdata | output | 8 | Byte read through the window, one cycle after the read |
| win_rvalid | output | 1 | `win_rdata` holds the result of the previous cycle's read |
| rx_head_page | input | clog2(PAGES) | Page at the head of the receive queue |
| pkt_num | input | clog2(PAGES) | Page held in the packet number register |
| mem_addr | output | clog2(PAGES)+ADDR_W | Page memory address of the current access |
| mem_we | output | 1 | Page memory write enable |
| mem_wdata | output | 8 | Page memory write data |

## Verification
The bench builds the block with four pages of the full 2048-byte size, using the banked memory variant. Four pages keep the receive-head page and the packet-number page apart across several values. The full 11-bit address makes the wrap from 0x7FF to 0 observable, both for the stepping pointer and for the lane-offset sum, while the control bits above it are held set. The default build uses a single flat array of two pages, so the bench parameters also exercise the per-page memory banks and their registered read select.

// File: rtl/pwp_pkg.sv
package pwp_pkg;

   localparam int PTR_W          = 16;
   localparam int BYTE_W         = 8;
   localparam int PAGE_SEL_BIT   = 15;
   localparam int AUTO_STEP_BIT  = 14;
   localparam logic [BYTE_W-1:0] HI_VIEW_MASK = 8'hF7;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

   function automatic logic [BYTE_W-1:0] hi_view(input logic [PTR_W-1:0] p);
      return p[PTR_W-1:BYTE_W] & HI_VIEW_MASK;
   endfunction

endpackage

// File: rtl/pwp_pointer.sv
module pwp_pointer
   import pwp_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_we,
   input  logic             hi_we,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);

   localparam int CTRL_W = PTR_W - ADDR_W;

   logic [ADDR_W-1:0] addr_next;
   logic [CTRL_W-1:0] ctrl_keep;

   assign addr_next = ptr[ADDR_W-1:0] + ADDR_W'(1);
   assign ctrl_keep = ptr[PTR_W-1:ADDR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (lo_we || hi_we) begin
         if (lo_we) ptr[BYTE_W-1:0]     <= wbyte;
         if (hi_we) ptr[PTR_W-1:BYTE_W] <= wbyte;
      end else if (step) begin
         ptr <= {ctrl_keep, addr_next};
      end
   end

endmodule

// File: rtl/pwp_access_ctl.sv
module pwp_access_ctl
   import pwp_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int PG_W   = 1,
   parameter int LANE_W = 2
) (
   input  logic              page_sel,
   input  logic              auto_step,
   input  logic [ADDR_W-1:0] ptr_addr,
   input  logic              ptr_loading,
   input  logic              win_we,
   input  logic              win_re,
   input  logic [LANE_W-1:0] lane,
   input  logic [PG_W-1:0]   rx_page,
   input  logic [PG_W-1:0]   num_page,
   output acc_kind_e         kind,
   output logic [PG_W-1:0]   page,
   output logic [ADDR_W-1:0] byte_addr,
   output logic              step
);

   always_comb begin
      if (win_we)      kind = ACC_WRITE;
      else if (win_re) kind = ACC_READ;
      else             kind = ACC_IDLE;
   end

   assign page      = page_sel ? rx_page : num_page;
   assign byte_addr = auto_step ? ptr_addr : ptr_addr + ADDR_W'(lane);
   assign step      = (kind != ACC_IDLE) && auto_step && !ptr_loading;

endmodule

// File: rtl/pwp_page_ram.sv
module pwp_page_ram
   import pwp_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int PAGES  = 2,
   parameter int PG_W   = 1,
   parameter bit BANKED = 1'b0
) (
   input  logic              clk,
   input  logic              we,
   input  logic              re,
   input  logic [PG_W-1:0]   page,
   input  logic [ADDR_W-1:0] byte_addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (BANKED) begin : g_banked
         logic [BYTE_W-1:0] bank_rd [PAGES];
         logic [PG_W-1:0]   sel_q;

         for (genvar g = 0; g < PAGES; g++) begin : g_bank
            logic [BYTE_W-1:0] cells [DEPTH];
            logic [BYTE_W-1:0] cell_q;
            logic              hit;

            assign hit = (page == PG_W'(g));

            always_ff @(posedge clk) begin
               if (we && hit) cells[byte_addr] <= wdata;
               if (re && hit) cell_q <= cells[byte_addr];
            end
            assign bank_rd[g] = cell_q;
         end

         always_ff @(posedge clk) begin
            if (re) sel_q <= page;
         end
         assign rdata = bank_rd[sel_q];
      end else begin : g_flat
         logic [BYTE_W-1:0] cells [PAGES*DEPTH];
         logic [BYTE_W-1:0] cell_q;
         logic [PG_W+ADDR_W-1:0] idx;

         assign idx = {page, byte_addr};

         always_ff @(posedge clk) begin
            if (we) cells[idx] <= wdata;
            if (re) cell_q <= cells[idx];
         end
         assign rdata = cell_q;
      end
   endgenerate

endmodule

// File: rtl/pkt_window_port.sv
module pkt_window_port
   import pwp_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int PAGES  = 2,
   parameter int LANES  = 4,
   parameter bit BANKED = 1'b0,
   localparam int PG_W   = (PAGES > 1) ? $clog2(PAGES) : 1,
   localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ptr_lo_we,
   input  logic                   ptr_hi_we,
   input  logic [7:0]             ptr_wbyte,
   output logic [7:0]             ptr_lo_rdata,
   output logic [7:0]             ptr_hi_rdata,
   input  logic                   win_we,
   input  logic                   win_re,
   input  logic [LANE_W-1:0]      win_lane,
   input  logic [7:0]             win_wdata,
   output logic [7:0]             win_rdata,
   output logic                   win_rvalid,
   input  logic [PG_W-1:0]        rx_head_page,
   input  logic [PG_W-1:0]        pkt_num,
   output logic [PG_W+ADDR_W-1:0] mem_addr,
   output logic                   mem_we,
   output logic [7:0]             mem_wdata
);

   generate
      if (ADDR_W < LANE_W || ADDR_W > 11) begin : g_bad_addr_w
         $error("pkt_window_port: ADDR_W must lie between the lane width and 11");
      end
      if (PAGES < 2 || (PAGES & (PAGES - 1)) != 0) begin : g_bad_pages
         $error("pkt_window_port: PAGES must be a power of two of at least 2");
      end
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("pkt_window_port: LANES must be a power of two of at least 2");
      end
   endgenerate

   logic [PTR_W-1:0]  ptr_q;
   acc_kind_e         kind;
   logic [PG_W-1:0]   page;
   logic [ADDR_W-1:0] byte_addr;
   logic              step;
   logic              loading;
   logic              rvalid_q;

   assign loading = ptr_lo_we || ptr_hi_we;

   pwp_pointer #(
      .ADDR_W (ADDR_W)
   ) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .lo_we (ptr_lo_we),
      .hi_we (ptr_hi_we),
      .wbyte (ptr_wbyte),
      .step  (step),
      .ptr   (ptr_q)
   );

   pwp_access_ctl #(
      .ADDR_W (ADDR_W),
      .PG_W   (PG_W),
      .LANE_W (LANE_W)
   ) u_ctl (
      .page_sel    (ptr_q[PAGE_SEL_BIT]),
      .auto_step   (ptr_q[AUTO_STEP_BIT]),
      .ptr_addr    (ptr_q[ADDR_W-1:0]),
      .ptr_loading (loading),
      .win_we      (win_we),
      .win_re      (win_re),
      .lane        (win_lane),
      .rx_page     (rx_head_page),
      .num_page    (pkt_num),
      .kind        (kind),
      .page        (page),
      .byte_addr   (byte_addr),
      .step        (step)
   );

   pwp_page_ram #(
      .ADDR_W (ADDR_W),
      .PAGES  (PAGES),
      .PG_W   (PG_W),
      .BANKED (BANKED)
   ) u_ram (
      .clk       (clk),
      .we        (kind == ACC_WRITE),
      .re        (kind == ACC_READ),
      .page      (page),
      .byte_addr (byte_addr),
      .wdata     (win_wdata),
      .rdata     (win_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid_q <= 1'b0;
      else        rvalid_q <= (kind == ACC_READ);
   end

   assign win_rvalid   = rvalid_q;
   assign ptr_lo_rdata = ptr_q[BYTE_W-1:0];
   assign ptr_hi_rdata = hi_view(ptr_q);
   assign mem_addr     = {page, byte_addr};
   assign mem_we       = (kind == ACC_WRITE);
   assign mem_wdata    = win_wdata;

endmodule

// File: rtl/pwp_checker.sv
module pwp_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ptr_lo_we,
   input logic       ptr_hi_we,
   input logic [7:0] ptr_lo_rdata,
   input logic [7:0] ptr_hi_rdata,
   input logic       win_we,
   input logic       win_re,
   input logic       win_rvalid,
   input logic       mem_we
);

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (ptr_lo_rdata == 8'h00 && ptr_hi_rdata == 8'h00 && !win_rvalid));

   // R3
   hi_view_bit3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_hi_rdata[3] == 1'b0);

   // R5
   manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_we || win_re) && !ptr_hi_rdata[6] && !ptr_lo_we && !ptr_hi_we
      |=> $stable(ptr_lo_rdata) && $stable(ptr_hi_rdata));

   // R6
   auto_ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_we || win_re) && ptr_hi_rdata[6] && !ptr_lo_we && !ptr_hi_we
      |=> ptr_hi_rdata[7:4] == $past(ptr_hi_rdata[7:4]));

   // R7
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_we |-> !mem_we);

   // R8
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_re && !win_we |=> win_rvalid);

   // R9
   collide_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_re && win_we |=> !win_rvalid);

   // R10
   lo_load_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_lo_we && !ptr_hi_we |=> ptr_hi_rdata == $past(ptr_hi_rdata));

endmodule

bind pkt_window_port pwp_checker u_chk (.*);

// File: tb/pkt_window_port_tb.sv
`timescale 1ns/1ps
module pkt_window_port_tb;

   localparam int AW  = 11;
   localparam int NP  = 4;
   localparam int PGW = 2;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           ptr_lo_we, ptr_hi_we;
   logic [7:0]     ptr_wbyte;
   logic [7:0]     ptr_lo_rdata, ptr_hi_rdata;
   logic           win_we, win_re;
   logic [1:0]     win_lane;
   logic [7:0]     win_wdata, win_rdata;
   logic           win_rvalid;
   logic [PGW-1:0] rx_head_page, pkt_num;
   logic [PGW+AW-1:0] mem_addr;
   logic           mem_we;
   logic [7:0]     mem_wdata;

   always #5 clk = ~clk;

   pkt_window_port #(.ADDR_W(AW), .PAGES(NP), .LANES(4), .BANKED(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ptr_lo_we(ptr_lo_we), .ptr_hi_we(ptr_hi_we), .ptr_wbyte(ptr_wbyte),
      .ptr_lo_rdata(ptr_lo_rdata), .ptr_hi_rdata(ptr_hi_rdata),
      .win_we(win_we), .win_re(win_re), .win_lane(win_lane),
      .win_wdata(win_wdata), .win_rdata(win_rdata), .win_rvalid(win_rvalid),
      .rx_head_page(rx_head_page), .pkt_num(pkt_num),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata)
   );

   int tests = 0;
   int fails = 0;

   // Behavioural reference state
   int         m_ptr;
   logic [7:0] m_mem [int];
   bit         m_rv;
   bit         m_known;
   int         m_rd;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // Drive one cycle of stimulus at the falling edge, compare, then advance the model.
   task automatic op(input bit lo, input bit hi, input int bval, input bit we,
                     input bit re, input int lane, input int wd, input string req);
      int pg, a, addr, nxt;
      bit acc;
      ptr_lo_we = lo; ptr_hi_we = hi; ptr_wbyte = bval[7:0];
      win_we = we; win_re = re; win_lane = lane[1:0]; win_wdata = wd[7:0];
      #1;
      acc  = we || re;
      pg   = m_ptr[15] ? int'(rx_head_page) : int'(pkt_num);
      a    = m_ptr[14] ? (m_ptr & 'h7FF) : ((m_ptr + lane) & 'h7FF);
      addr = pg * (1 << AW) + a;
      if (acc) chk(int'(mem_addr) == addr, req, "mem_addr", int'(mem_addr), addr);
      chk(mem_we == we, "R7", "mem_we", int'(mem_we), int'(we));
      if (we) chk(int'(mem_wdata) == wd, "R7", "mem_wdata", int'(mem_wdata), wd);
      chk(int'(ptr_lo_rdata) == (m_ptr & 'hFF), "R2", "ptr_lo", int'(ptr_lo_rdata), m_ptr & 'hFF);
      chk(int'(ptr_hi_rdata) == ((m_ptr >> 8) & 'hF7), "R3", "ptr_hi",
          int'(ptr_hi_rdata), (m_ptr >> 8) & 'hF7);
      chk(win_rvalid == m_rv, "R8", "win_rvalid", int'(win_rvalid), int'(m_rv));
      if (m_rv && m_known)
         chk(int'(win_rdata) == m_rd, req, "win_rdata", int'(win_rdata), m_rd);
      // next model state
      nxt = m_ptr;
      if (lo || hi) begin
         if (lo) nxt = (nxt & 'hFF00) | (bval & 'hFF);
         if (hi) nxt = (nxt & 'h00FF) | ((bval & 'hFF) << 8);
      end else if (acc && m_ptr[14]) begin
         nxt = (m_ptr & 'hF800) | ((m_ptr + 1) & 'h7FF);
      end
      m_rv = re && !we;
      if (m_rv) begin
         m_known = m_mem.exists(addr);
         m_rd    = m_known ? int'(m_mem[addr]) : 0;
      end
      if (we) m_mem[addr] = wd[7:0];
      @(posedge clk);
      m_ptr = nxt;
      @(negedge clk);
   endtask

   task automatic idle(input string req);
      op(0, 0, 0, 0, 0, 0, 0, req);
   endtask

   task automatic set_ptr(input int v, input string req);
      op(1, 0, v & 'hFF, 0, 0, 0, 0, req);
      op(0, 1, (v >> 8) & 'hFF, 0, 0, 0, 0, req);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      ptr_lo_we = 0; ptr_hi_we = 0; ptr_wbyte = 0;
      win_we = 0; win_re = 0; win_lane = 0; win_wdata = 0;
      rx_head_page = 0; pkt_num = 0;
      m_ptr = 0; m_rv = 0; m_known = 0; m_rd = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ptr_lo_rdata == 8'h00, "R1", "ptr_lo in reset", int'(ptr_lo_rdata), 0);
      chk(ptr_hi_rdata == 8'h00, "R1", "ptr_hi in reset", int'(ptr_hi_rdata), 0);
      chk(win_rvalid == 1'b0, "R1", "rvalid in reset", int'(win_rvalid), 0);
      rst_n = 1'b1;
      idle("R1");

      // R2 byte-wise pointer loads
      op(1, 0, 'h34, 0, 0, 0, 0, "R2");
      op(0, 1, 'h02, 0, 0, 0, 0, "R2");
      idle("R2");
      // R3 high view masks bit 11
      op(0, 1, 'hFF, 0, 0, 0, 0, "R3");
      idle("R3");

      // R6 stepping writes into packet-number page, lane ignored
      pkt_num = 1; rx_head_page = 0;
      set_ptr('h4010, "R6");
      for (int i = 0; i < 8; i++) op(0, 0, 0, 1, 0, (i * 3) % 4, 'hA0 + i, "R6");
      idle("R6");

      // R5 manual reads with lane offsets, pointer held
      set_ptr('h0010, "R5");
      for (int l = 0; l < 4; l++) op(0, 0, 0, 0, 1, l, 0, "R5");
      set_ptr('h0014, "R5");
      for (int l = 0; l < 4; l++) op(0, 0, 0, 0, 1, l, 0, "R5");
      idle("R8");

      // R4 page select through bit 15
      rx_head_page = 2; pkt_num = 1;
      set_ptr('hC000, "R4");
      for (int i = 0; i < 4; i++) op(0, 0, 0, 1, 0, 0, 'h10 + i, "R4");
      rx_head_page = 3; pkt_num = 2;
      set_ptr('h0000, "R4");
      for (int l = 0; l < 4; l++) op(0, 0, 0, 0, 1, l, 0, "R4");
      rx_head_page = 1; pkt_num = 0;
      set_ptr('h8010, "R4");
      op(0, 0, 0, 0, 1, 1, 0, "R4");
      idle("R4");

      // R6 wrap of the address field with control bits set
      rx_head_page = 3; pkt_num = 3;
      set_ptr('h7FFF, "R6");
      op(0, 0, 0, 1, 0, 2, 'h5A, "R6");
      op(0, 0, 0, 1, 0, 1, 'h5B, "R6");
      idle("R6");
      // R5 lane sum wraps inside the address field
      set_ptr('h07FE, "R5");
      op(0, 0, 0, 0, 1, 1, 0, "R5");
      op(0, 0, 0, 0, 1, 2, 0, "R5");
      idle("R5");

      // R9 read and write in the same cycle
      pkt_num = 0;
      set_ptr('h4020, "R9");
      op(0, 0, 0, 1, 1, 0, 'h77, "R9");
      idle("R9");
      set_ptr('h0020, "R9");
      op(0, 0, 0, 0, 1, 0, 0, "R9");
      idle("R9");

      // R10 pointer load wins over stepping
      set_ptr('h40FF, "R10");
      op(1, 0, 'h30, 1, 0, 0, 'h66, "R10");
      idle("R10");
      op(1, 0, 'hFF, 0, 0, 0, 0, "R10");
      op(0, 1, 'h00, 0, 1, 0, 0, "R10");
      idle("R10");

      // R8 streaming reads, one byte per cycle
      pkt_num = 1;
      set_ptr('h4010, "R8");
      for (int i = 0; i < 8; i++) op(0, 0, 0, 0, 1, 0, 0, "R8");
      idle("R8");
      idle("R8");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule